// File: doc/BRIEF.md
# DAC Control Register Interface

This block is the digital front end of a 12-bit voltage-output converter. It holds three byte-wide registers on an 8-bit register bus: a control byte and two data bytes that together form the code. Software writes them with an address, a data byte and a write strobe, and can read all three back. The block turns their contents into a latched 12-bit code for the converter core. It also produces the enable, output-range and output-pin select levels for the analog circuits, which are outside this block.

The code that reaches the converter changes only when the low data byte is written. Software therefore writes the high byte first and the low byte last, and the converter never sees a half-updated value. A mode bit selects between two formats. In the 12-bit format the value is right-justified across the two bytes. In the 8-bit format the low byte alone drives the top of the code. A clear bit, while low, holds the data bytes and the code at zero. Powering the converter down leaves the code untouched.

Top module: `dac_regif`

## Requirements
- R1: After reset, all three registers read back 0x00, the code is 0, and the enable, range and pin outputs are low.
- R2: A write to address 0xFD stores data bits 4:0 in the control register. Reading 0xFD returns those five bits, and bits 7:5 always read as zero.
- R3: Control bit 0 drives `dac_enable` (1 means powered). Control bit 2 drives `dac_range_supply` (1 means supply range, 0 means reference range). Control bit 4 drives `dac_pin_alt` (1 means the common pin, 0 means the dedicated pin).
- R4: A write to the high byte at 0xFC stores all 8 bits and reads back as written. It leaves the code unchanged.
- R5: With control bit 3 at 0 (12-bit format), a write to the low byte at 0xFB loads the code with bits 11:8 taken from high-byte bits 3:0 and bits 7:0 taken from the written byte. The new code is visible from the next clock.
- R6: With control bit 3 at 1 (8-bit format), a write to the low byte loads the code with the written byte in bits 11:4 and zeros in bits 3:0.
- R7: While control bit 1 is 0, both data bytes and the code are held at zero from the next clock, and writes to the data bytes are ignored.
- R8: Clearing control bit 0 (power-down) keeps the code. Setting it again restores the same output code.
- R9: A change of format, range, pin or enable bits, without a low-byte write, leaves the code unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_rdata | output | 8 | Readback of the addressed register (combinational) |
| dac_code | output | 12 | Latched code to the converter core |
| dac_enable | output | 1 | Converter power enable |
| dac_range_supply | output | 1 | 1 selects supply range, 0 selects reference range |
| dac_pin_alt | output | 1 | 1 routes the output to the common pin |

## Verification
The bench first targets write ordering.

- A design that latched the code on a high-byte write would show a half-updated code after a high-only write.
- A design that fetched the nibble from the wrong place would load the wrong bits 11:8 when the low byte follows.

Format switching is checked with the low byte written in both modes and with the mode bit flipped between writes.

- Picking up the wrong justification shows as a code shifted by four bits.
- Re-muxing without a write moves the code on a mode change alone.

The clear and power-down bits are toggled around data writes.

- A leaky clear lets a write land in a data byte while clear is low.
- A power-down that zeroed the code would lose the value on re-enable.

// File: rtl/dac_regif_pkg.sv
// Package: shared types for the DAC register interface.
// Assumes the control byte layout below, which the output pins decode.
package dac_regif_pkg;

    // Implemented control bits, MSB first: bit4 .. bit0.
    typedef struct packed {
        logic pin_alt;       // bit 4: output routed to common pin
        logic mode8;         // bit 3: 8-bit left-justified format
        logic range_supply;  // bit 2: full supply range
        logic clr_n;         // bit 1: 0 holds data and code at zero
        logic enable;        // bit 0: converter powered
    } ctrl_t;

    localparam int unsigned CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/dac_ctrl_reg.sv
// Module: dac_ctrl_reg
// Holds the implemented control bits. Assumes the caller decodes the
// address and passes only the implemented data bits.
module dac_ctrl_reg
    import dac_regif_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wdata,
    output ctrl_t             ctrl
);

    // Capture the control byte on a decoded write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl <= '0;
        else if (wr_en)
            ctrl <= ctrl_t'(wdata);
    end

    // R2
    ctrl_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (ctrl == ctrl_t'($past(wdata))));

endmodule

// File: rtl/dac_data_regs.sv
// Module: dac_data_regs
// The two data bytes (index 0 = low, 1 = high). While clr_n is low,
// both bytes are forced to zero and writes are dropped. Assumes at
// most one write strobe is active per cycle.
module dac_data_regs #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_n,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] lo_q,
    output logic [DATA_W-1:0] hi_q
);

    localparam int unsigned NBYTES = 2;

    logic [NBYTES-1:0] wr_vec;
    logic [DATA_W-1:0] byte_q [NBYTES];

    assign wr_vec = {wr_hi, wr_lo};

    for (genvar i = 0; i < NBYTES; i++) begin : g_byte
        // One byte register: cleared, written or held.
        always_ff @(posedge clk) begin
            if (!rst_n || !clr_n)
                byte_q[i] <= '0;
            else if (wr_vec[i])
                byte_q[i] <= wdata;
        end
    end

    assign lo_q = byte_q[0];
    assign hi_q = byte_q[1];

    // R7
    data_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n |=> (lo_q == '0 && hi_q == '0));

    // R4
    hi_write_keeps_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hi && clr_n) |=> $stable(lo_q));

endmodule

// File: rtl/dac_code_latch.sv
// Module: dac_code_latch
// Builds the converter code from the written low byte and the stored high
// nibble, in the selected format, and latches it only on a low-byte write.
// Assumes the high nibble input is the current stored high byte.
module dac_code_latch #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned CODE_W = 12
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr_n,
    input  logic                     mode8,
    input  logic                     wr_lo,
    input  logic [DATA_W-1:0]        lo_wdata,
    input  logic [CODE_W-DATA_W-1:0] hi_nib,
    output logic [CODE_W-1:0]        code
);

    localparam int unsigned EXT_W = CODE_W - DATA_W;

    logic [CODE_W-1:0] next_code;

    // Format mux: left-justified byte or right-justified nibble+byte.
    always_comb begin
        if (mode8)
            next_code = {lo_wdata, {EXT_W{1'b0}}};
        else
            next_code = {hi_nib, lo_wdata};
    end

    // Output latch: cleared by the clear bit, loaded on a low-byte write.
    always_ff @(posedge clk) begin
        if (!rst_n || !clr_n)
            code <= '0;
        else if (wr_lo)
            code <= next_code;
    end

    // R5
    code_wide_fmt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lo && clr_n && !mode8) |=>
            (code[DATA_W-1:0] == $past(lo_wdata) && code[CODE_W-1:DATA_W] == $past(hi_nib)));

    // R6
    code_byte_fmt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lo && clr_n && mode8) |=>
            (code[CODE_W-1:EXT_W] == $past(lo_wdata) && code[EXT_W-1:0] == '0));

    // R9
    code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_n && !wr_lo) |=> $stable(code));

    // R7
    code_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n |=> (code == '0));

endmodule

// File: rtl/dac_regif.sv
// Module: dac_regif (top)
// Register-bus front end for a voltage DAC: decodes writes to the control
// and data bytes, returns readback, and drives the latched code and the
// analog control levels. Assumes one bus access per cycle.
module dac_regif
    import dac_regif_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 8,
    parameter int unsigned CODE_W = 12,
    parameter logic [ADDR_W-1:0] ADDR_CTRL = 8'hFD,
    parameter logic [ADDR_W-1:0] ADDR_LO   = 8'hFB,
    parameter logic [ADDR_W-1:0] ADDR_HI   = 8'hFC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_we,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [CODE_W-1:0] dac_code,
    output logic              dac_enable,
    output logic              dac_range_supply,
    output logic              dac_pin_alt
);

    localparam int unsigned EXT_W = CODE_W - DATA_W;

    ctrl_t             ctrl;
    logic              wr_ctrl, wr_lo, wr_hi;
    logic [DATA_W-1:0] lo_q, hi_q;

    // Write address decode.
    always_comb begin
        wr_ctrl = bus_we && (bus_addr == ADDR_CTRL);
        wr_lo   = bus_we && (bus_addr == ADDR_LO);
        wr_hi   = bus_we && (bus_addr == ADDR_HI);
    end

    dac_ctrl_reg u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_ctrl),
        .wdata (bus_wdata[CTRL_W-1:0]),
        .ctrl  (ctrl)
    );

    dac_data_regs #(.DATA_W(DATA_W)) u_data (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_n (ctrl.clr_n),
        .wr_lo (wr_lo),
        .wr_hi (wr_hi),
        .wdata (bus_wdata),
        .lo_q  (lo_q),
        .hi_q  (hi_q)
    );

    dac_code_latch #(.DATA_W(DATA_W), .CODE_W(CODE_W)) u_code (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_n    (ctrl.clr_n),
        .mode8    (ctrl.mode8),
        .wr_lo    (wr_lo),
        .lo_wdata (bus_wdata),
        .hi_nib   (hi_q[EXT_W-1:0]),
        .code     (dac_code)
    );

    // Readback mux; unimplemented control bits return zero.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_CTRL)
            bus_rdata = DATA_W'(ctrl);
        else if (bus_addr == ADDR_LO)
            bus_rdata = lo_q;
        else if (bus_addr == ADDR_HI)
            bus_rdata = hi_q;
    end

    // Analog control levels.
    always_comb begin
        dac_enable       = ctrl.enable;
        dac_range_supply = ctrl.range_supply;
        dac_pin_alt      = ctrl.pin_alt;
    end

    // R8
    powerdown_keeps_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && bus_wdata[1]) |=> $stable(dac_code));

    // R3
    enable_follows_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctrl |=> (dac_enable == $past(bus_wdata[0]) && dac_pin_alt == $past(bus_wdata[4])));

endmodule

// File: tb/dac_regif_bench.sv
// Bench for dac_regif: directed corner cases, then seeded random writes,
// all compared against a bench-side model of the registers and code.
module dac_regif_bench;

    localparam logic [7:0] A_CTRL = 8'hFD;
    localparam logic [7:0] A_LO   = 8'hFB;
    localparam logic [7:0] A_HI   = 8'hFC;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_rdata;
    logic [11:0] dac_code;
    logic        dac_enable, dac_range_supply, dac_pin_alt;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [4:0]  m_ctrl = '0;
    logic [7:0]  m_lo = '0;
    logic [7:0]  m_hi = '0;
    logic [11:0] m_code = '0;

    always #4 clk = ~clk;

    dac_regif u_dac_regif (
        .clk              (clk),
        .rst_n            (rst_n),
        .bus_addr         (bus_addr),
        .bus_wdata        (bus_wdata),
        .bus_we           (bus_we),
        .bus_rdata        (bus_rdata),
        .dac_code         (dac_code),
        .dac_enable       (dac_enable),
        .dac_range_supply (dac_range_supply),
        .dac_pin_alt      (dac_pin_alt)
    );

    // Expected code from the format rules (R5, R6).
    function automatic logic [11:0] f_code(input logic mode8, input logic [7:0] lo,
                                           input logic [7:0] hi);
        return mode8 ? {lo, 4'h0} : {hi[3:0], lo};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    // Bus write, then one idle cycle; updates the model.
    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
        @(negedge clk);
        if (a == A_CTRL) begin
            m_ctrl = d[4:0];
            if (!d[1]) begin m_lo = '0; m_hi = '0; m_code = '0; end
        end else if (a == A_LO && m_ctrl[1]) begin
            m_code = f_code(m_ctrl[3], d, m_hi);
            m_lo = d;
        end else if (a == A_HI && m_ctrl[1]) begin
            m_hi = d;
        end
    endtask

    task automatic check_all(input string tag);
        logic [7:0] d;
        rd(A_CTRL, d); chk("R2 ctrl readback", d, {3'b000, m_ctrl});
        rd(A_LO, d);   chk({tag, " low readback"}, d, m_lo);
        rd(A_HI, d);   chk({tag, " high readback"}, d, m_hi);
        chk({tag, " code"}, dac_code, m_code);
        chk("R3 enable", dac_enable, m_ctrl[0]);
        chk("R3 range", dac_range_supply, m_ctrl[2]);
        chk("R3 pin", dac_pin_alt, m_ctrl[4]);
    endtask

    initial begin
        logic [7:0] d;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(A_CTRL, d); chk("R1 ctrl reset", d, 8'h00);
        rd(A_LO, d);   chk("R1 low reset", d, 8'h00);
        rd(A_HI, d);   chk("R1 high reset", d, 8'h00);
        chk("R1 code reset", dac_code, 12'h000);
        chk("R1 outputs reset", {dac_enable, dac_range_supply, dac_pin_alt}, 3'b000);

        // R2 upper control bits read zero
        wr(A_CTRL, 8'hFF);
        rd(A_CTRL, d); chk("R2 upper bits zero", d, 8'h1F);
        chk("R3 all levels high", {dac_enable, dac_range_supply, dac_pin_alt}, 3'b111);

        // R4 high write alone does not move the code
        wr(A_CTRL, 8'h03);
        wr(A_HI, 8'hA5);
        rd(A_HI, d); chk("R4 high stored", d, 8'hA5);
        chk("R4 code unchanged", dac_code, 12'h000);

        // R5 right-justified load
        wr(A_LO, 8'h3C);
        chk("R5 wide code", dac_code, 12'h53C);

        // R9 format change without write
        wr(A_CTRL, 8'h0B);
        chk("R9 code held on mode change", dac_code, 12'h53C);

        // R6 left-justified load
        wr(A_LO, 8'hC3);
        chk("R6 byte code", dac_code, 12'hC30);

        // R8 power down and back
        wr(A_CTRL, 8'h0A);
        chk("R8 disabled", dac_enable, 1'b0);
        chk("R8 code kept while down", dac_code, 12'hC30);
        wr(A_CTRL, 8'h0B);
        chk("R8 code restored", dac_code, 12'hC30);

        // R7 clear and ignored writes
        wr(A_CTRL, 8'h09);
        chk("R7 code cleared", dac_code, 12'h000);
        rd(A_LO, d); chk("R7 low cleared", d, 8'h00);
        wr(A_LO, 8'h77);
        wr(A_HI, 8'h66);
        rd(A_LO, d); chk("R7 low write ignored", d, 8'h00);
        rd(A_HI, d); chk("R7 high write ignored", d, 8'h00);
        chk("R7 code stays zero", dac_code, 12'h000);
        check_all("R7");

        // Random phase
        for (int i = 0; i < 400; i++) begin
            int op;
            logic [7:0] v;
            op = int'($urandom_range(0, 9));
            v = 8'($urandom());
            if (op < 2) begin
                if (op == 0) v[1] = 1'b1;
                else if ($urandom_range(0, 3) != 0) v[1] = 1'b1;
                wr(A_CTRL, v);
                check_all("R9 ctrl write");
            end else if (op < 5) begin
                wr(A_HI, v);
                check_all("R4 high write");
            end else begin
                wr(A_LO, v);
                check_all(m_ctrl[3] ? "R6 low write" : "R5 low write");
            end
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule